// File: doc/BRIEF.md
# Multi-Source 16-bit Timer/Event Counter

This block is a 16-bit up-counter whose count source comes from a 2-bit select input. The select can hold the counter, or make it count one of three sources. The first is the system clock, either undivided or through a prescaler. The second is falling edges on an asynchronous external pin. The third is the internal clock, allowed through only while that pin is high. The prescaler divides by 12, or by 24 when its extra halving stage is switched on. The pin passes through a two-flop synchronizer, so edge detection and gating both work on a clean level.

Software can overwrite the count one byte at a time through a simple write strobe per byte. A sticky flag records each wrap from 0xFFFF to 0x0000. The reset input is asynchronous and active low, and its release is synchronized inside the block. The block is meant for interval timing, event counting, and measuring how long an external signal stays high.

Top module: `evt_timer16`

## Requirements
- R1: With `src_sel` = 2'b00 and no byte write, the count holds its value on every clock, whatever `ext_pin` does.
- R2: With `src_sel` = 2'b01 and `pre_on` = 0, the count rises by exactly one on every clock edge.
- R3: With `src_sel` = 2'b01, `pre_on` = 1 and `pre_dbl` = 0, the count rises by exactly M over any run of 12*M clocks.
- R4: With `src_sel` = 2'b01, `pre_on` = 1 and `pre_dbl` = 1, the count rises by exactly M over any run of 24*M clocks.
- R5: With `src_sel` = 2'b10, each 1-to-0 transition of `ext_pin` adds exactly one to the count. A 0-to-1 transition adds nothing.
- R6: In edge-counting mode, a fall of `ext_pin` set up before clock edge k first appears on `count` after edge k+2.
- R7: With `src_sel` = 2'b11, the count takes internal ticks (undivided or prescaled, chosen by `pre_on`) only while the synchronized pin is high. A high window of H clocks adds H undivided ticks, or M ticks for a window of 12*M clocks at divide-by-12. A low pin adds nothing.
- R8: `wr_lo` loads `wr_data` into `count[7:0]` and `wr_hi` loads it into `count[15:8]` at the next edge. A byte that is not written keeps its value.
- R9: In any cycle that has a byte write, the increment is suppressed. A write of 0xFF into the low byte at 0xFFFF while counting leaves 0xFFFF and does not set the flag.
- R10: `ovf_flag` goes to 1 at the edge where an increment wraps the count from 0xFFFF to 0x0000, and at no other time.
- R11: `ovf_flag` stays at 1 until a cycle with `ovf_wr` = 1 and `ovf_wdata` = 0. Writing 1 has no effect. A wrap in the same cycle as a clear leaves the flag at 1.
- R12: While `rst_n` is low, the count and the flag are zero. After `rst_n` rises, the first increment lands on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external count/gate pin |
| src_sel | input | 2 | Count source: 00 hold, 01 internal clock, 10 pin falling edges, 11 gated internal clock |
| pre_on | input | 1 | 1 = internal clock taken through the prescaler |
| pre_dbl | input | 1 | 1 = prescaler divides by 24 instead of 12 |
| wr_lo | input | 1 | Write strobe for the low count byte |
| wr_hi | input | 1 | Write strobe for the high count byte |
| wr_data | input | 8 | Byte write data |
| ovf_wr | input | 1 | Write strobe for the overflow flag |
| ovf_wdata | input | 1 | Flag write value (only 0 has an effect) |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
Byte writes, internal-clock increments and flag updates take effect at the first clock edge after the inputs are applied. A pin fall first shows on `count` two edges later, because it passes two synchronizer flops and a previous-sample flop, and gated windows are shifted by the same two edges. The bench drives and samples on the falling clock edge. Each run in a counting mode is bracketed by hold mode, with at least four settling cycles after the last pin change, so every sweep compares a whole-window difference with its arithmetic expectation. The latency test samples the count after each of the three edges separately.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    SRC_HALT    = 2'b00,
    SRC_SYSCLK  = 2'b01,
    SRC_PINEDGE = 2'b10,
    SRC_GATED   = 2'b11
  } src_mode_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_in_sync.sv
module tmr_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_level,
  output logic pin_fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // synchronizer chain, stage 0 sees the raw pin
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_d[g] = pin_async;
      end else begin : g_next
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pin_level = sync_q[STAGES-1];
  assign pin_fall  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_BASE  = 12,
  parameter int DIV_EXTRA = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_on,
  input  logic pre_dbl,
  output logic tick
);
  localparam int MAX_DIV = DIV_BASE * DIV_EXTRA;
  localparam int PW      = $clog2(MAX_DIV);
  localparam logic [PW-1:0] LIM_BASE = PW'(DIV_BASE - 1);
  localparam logic [PW-1:0] LIM_MAX  = PW'(MAX_DIV - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] div_d;
  logic [PW-1:0] lim;
  logic          wrap;

  always_comb begin
    lim   = pre_dbl ? LIM_MAX : LIM_BASE;
    wrap  = (div_q >= lim);
    div_d = wrap ? '0 : div_q + PW'(1);
    tick  = pre_on ? wrap : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTE  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc,
  input  logic [NBYTE-1:0]        wr_be,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    ovf_wr,
  input  logic                    ovf_wdata,
  output logic [NBYTE*BYTE_W-1:0] cnt,
  output logic                    ovf
);
  localparam int CW = NBYTE * BYTE_W;

  logic [CW-1:0] cnt_d;
  logic [CW-1:0] sum;
  logic          carry;
  logic          any_wr;
  logic          step;
  logic          ovf_d;

  always_comb begin
    any_wr       = |wr_be;
    step         = inc & ~any_wr;
    {carry, sum} = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    cnt_d        = step ? sum : cnt;
    for (int i = 0; i < NBYTE; i++) begin
      if (wr_be[i]) cnt_d[i*BYTE_W +: BYTE_W] = wr_data;
    end
    if (step && carry)            ovf_d = 1'b1;
    else if (ovf_wr && !ovf_wdata) ovf_d = 1'b0;
    else                           ovf_d = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_d;
      ovf <= ovf_d;
    end
  end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16 #(
  parameter int BYTE_W    = 8,
  parameter int SYNC_ST   = 2,
  parameter int DIV_BASE  = 12,
  parameter int DIV_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic [1:0]        src_sel,
  input  logic              pre_on,
  input  logic              pre_dbl,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_wr,
  input  logic              ovf_wdata,
  output logic [2*BYTE_W-1:0] count,
  output logic              ovf_flag
);
  import evt_timer_pkg::*;

  logic      rst_n_int;
  logic      pin_level;
  logic      pin_fall;
  logic      clk_tick;
  logic      cnt_inc;
  src_mode_e mode;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  tmr_in_sync #(.STAGES(SYNC_ST)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pin_async (ext_pin),
    .pin_level (pin_level),
    .pin_fall  (pin_fall)
  );

  tmr_prescale #(.DIV_BASE(DIV_BASE), .DIV_EXTRA(DIV_EXTRA)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .pre_on  (pre_on),
    .pre_dbl (pre_dbl),
    .tick    (clk_tick)
  );

  always_comb begin
    mode = src_mode_e'(src_sel);
    unique case (mode)
      SRC_HALT:    cnt_inc = 1'b0;
      SRC_SYSCLK:  cnt_inc = clk_tick;
      SRC_PINEDGE: cnt_inc = pin_fall;
      SRC_GATED:   cnt_inc = clk_tick & pin_level;
      default:     cnt_inc = 1'b0;
    endcase
  end

  tmr_counter #(.BYTE_W(BYTE_W), .NBYTE(2)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .inc       (cnt_inc),
    .wr_be     ({wr_hi, wr_lo}),
    .wr_data   (wr_data),
    .ovf_wr    (ovf_wr),
    .ovf_wdata (ovf_wdata),
    .cnt       (count),
    .ovf       (ovf_flag)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n_int,
  input logic [1:0]          src_sel,
  input logic                pre_on,
  input logic                wr_lo,
  input logic                wr_hi,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                ovf_wr,
  input logic                ovf_wdata,
  input logic                cnt_inc,
  input logic [2*BYTE_W-1:0] count,
  input logic                ovf_flag
);
  localparam logic [2*BYTE_W-1:0] ALL1 = '1;
  localparam logic [2*BYTE_W-1:0] ONE  = {{(2*BYTE_W-1){1'b0}}, 1'b1};

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (src_sel == 2'b00 && !wr_lo && !wr_hi) |=> count == $past(count));

  assert_sysclk_step_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (src_sel == 2'b01 && !pre_on && !wr_lo && !wr_hi) |=> count == $past(count) + ONE);

  assert_lo_load_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_lo |=> count[BYTE_W-1:0] == $past(wr_data));

  assert_hi_load_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_hi |=> count[2*BYTE_W-1:BYTE_W] == $past(wr_data));

  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!wr_lo && !wr_hi) |=> (count == $past(count) || count == $past(count) + ONE));

  assert_wrap_sets_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cnt_inc && count == ALL1 && !wr_lo && !wr_hi) |=> ovf_flag);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!ovf_flag && !(cnt_inc && count == ALL1 && !wr_lo && !wr_hi)) |=> !ovf_flag);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ovf_flag && !(ovf_wr && !ovf_wdata)) |=> ovf_flag);
endmodule

bind evt_timer16 tmr_checker #(.BYTE_W(BYTE_W)) u_tmr_checker (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .src_sel   (src_sel),
  .pre_on    (pre_on),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .wr_data   (wr_data),
  .ovf_wr    (ovf_wr),
  .ovf_wdata (ovf_wdata),
  .cnt_inc   (cnt_inc),
  .count     (count),
  .ovf_flag  (ovf_flag)
);

// File: tb/test_evt_timer16.sv
`timescale 1ns/1ps
module test_evt_timer16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_pin;
  logic [1:0]  src_sel;
  logic        pre_on, pre_dbl;
  logic        wr_lo, wr_hi;
  logic [7:0]  wr_data;
  logic        ovf_wr, ovf_wdata;
  logic [15:0] count;
  logic        ovf_flag;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  evt_timer16 i_evt_timer16 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .src_sel(src_sel),
    .pre_on(pre_on), .pre_dbl(pre_dbl), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata),
    .count(count), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbyte(input bit hi, input logic [7:0] d);
    wr_lo = ~hi; wr_hi = hi; wr_data = d;
    step(1);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic wflag(input bit v);
    ovf_wr = 1'b1; ovf_wdata = v;
    step(1);
    ovf_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    rst_n = 1'b0; ext_pin = 1'b0; src_sel = 2'b01; pre_on = 1'b0; pre_dbl = 1'b0;
    wr_lo = 1'b0; wr_hi = 1'b0; wr_data = 8'h00; ovf_wr = 1'b0; ovf_wdata = 1'b0;
    step(3);
    chk("R12 count in reset", count, 0);
    chk("R12 flag in reset", ovf_flag, 0);
    rst_n = 1'b1;
    step(1); chk("R12 edge1", count, 0);
    step(1); chk("R12 edge2", count, 0);
    step(1); chk("R12 edge3", count, 1);
    src_sel = 2'b00; step(1);

    // R1: hold mode ignores pin toggles
    c0 = count;
    for (int i = 0; i < 40; i++) begin ext_pin = i[1]; step(1); end
    ext_pin = 1'b1; step(4);
    chk("R1 hold", count, c0);

    // R2: undivided internal clock
    for (int n = 1; n <= 20; n += 3) begin
      c0 = count; src_sel = 2'b01; step(n); src_sel = 2'b00; step(1);
      chk("R2 sysclk", count, 16'(c0 + n));
    end

    // R3 / R4: prescaled
    pre_on = 1'b1;
    for (int m = 1; m <= 3; m++) begin
      c0 = count; src_sel = 2'b01; step(12*m); src_sel = 2'b00; step(1);
      chk("R3 div12", count, 16'(c0 + m));
    end
    pre_dbl = 1'b1;
    for (int m = 1; m <= 2; m++) begin
      c0 = count; src_sel = 2'b01; step(24*m); src_sel = 2'b00; step(1);
      chk("R4 div24", count, 16'(c0 + m));
    end
    pre_dbl = 1'b0; pre_on = 1'b0;

    // R5: edge counting, pin currently high and settled
    ext_pin = 1'b0; step(4); src_sel = 2'b10; step(1);
    c0 = count; ext_pin = 1'b1; step(5);
    chk("R5 rise ignored", count, c0);
    for (int w = 1; w <= 3; w++) begin
      for (int k = 0; k <= 5; k++) begin
        c0 = count;
        for (int e = 0; e < k; e++) begin
          ext_pin = 1'b0; step(w); ext_pin = 1'b1; step(w);
        end
        step(4);
        chk("R5 falls", count, 16'(c0 + k));
      end
    end

    // R6: latency of one fall
    c0 = count; ext_pin = 1'b0;
    step(1); chk("R6 after k", count, c0);
    step(1); chk("R6 after k+1", count, c0);
    step(1); chk("R6 after k+2", count, 16'(c0 + 1));
    step(3); src_sel = 2'b00; step(1);

    // R7: gated mode
    src_sel = 2'b11; c0 = count; step(30);
    chk("R7 low blocks", count, c0);
    for (int h = 1; h <= 8; h++) begin
      c0 = count; ext_pin = 1'b1; step(h); ext_pin = 1'b0; step(4);
      chk("R7 gated window", count, 16'(c0 + h));
    end
    pre_on = 1'b1;
    for (int m = 1; m <= 2; m++) begin
      c0 = count; ext_pin = 1'b1; step(12*m); ext_pin = 1'b0; step(4);
      chk("R7 gated div12", count, 16'(c0 + m));
    end
    pre_on = 1'b0; src_sel = 2'b00; step(1);

    // R8: byte writes
    wbyte(1'b0, 8'h34); chk("R8 lo", count[7:0], 8'h34);
    c0 = count;
    wbyte(1'b1, 8'h12); chk("R8 hi", count, {8'h12, c0[7:0]});
    wbyte(1'b0, 8'hA5); chk("R8 lo keeps hi", count, 16'h12A5);

    // R9 / R10: write priority and wrap
    wbyte(1'b1, 8'hFF); wbyte(1'b0, 8'hFF);
    wflag(1'b0);
    src_sel = 2'b01; wr_lo = 1'b1; wr_data = 8'hFF;
    step(1); wr_lo = 1'b0;
    chk("R9 write wins", count, 16'hFFFF);
    chk("R9 no flag", ovf_flag, 0);
    step(1);
    chk("R10 wrap count", count, 16'h0000);
    chk("R10 wrap flag", ovf_flag, 1);
    src_sel = 2'b00;

    // R11: sticky flag
    step(10); chk("R11 held", ovf_flag, 1);
    wflag(1'b1); chk("R11 write1 ignored", ovf_flag, 1);
    wflag(1'b0); chk("R11 cleared", ovf_flag, 0);
    wbyte(1'b1, 8'hFF); wbyte(1'b0, 8'hFF);
    src_sel = 2'b01; ovf_wr = 1'b1; ovf_wdata = 1'b0;
    step(1); ovf_wr = 1'b0; src_sel = 2'b00;
    chk("R11 set beats clear", ovf_flag, 1);
    chk("R10 wrap again", count, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule